// File: doc/BRIEF.md
# Processor Reset Sequencer Register Slice

This block is a small register slice that controls reset for a pair of processor cores and their cache flush requests. Each core has one 32-bit word on a simple register bus (address, write data, write strobe, combinational read data). Every writable bit in a word has a write-enable partner sixteen positions higher, so software can change one field without a read-modify-write cycle. A control bit, or a done-flag clear, only takes effect when its write-enable partner is one in the same write.

Setting a core's reset control bit starts a timed sequence. The core's clock enable is pulled low for a programmed phase, the reset output rises while the clock is stopped, and reset is later removed while the clock is still stopped. One core, the self-clearing one (core 0), runs the whole apply-and-remove sequence from a single write. The other core (core 1) holds reset with its clock running until software clears the bit. A sticky done flag records each completed removal. A separate flush request bit stays high until the cache reports completion.

Each clock-stop phase lasts `stopTicks * TICK_CYCLES + 1` clock cycles. `TICK_CYCLES` is the number of clocks in one quarter-microsecond tick, and `stopTicks` is a 4-bit count of ticks (at most 3.75 µs). `stopTicks` is sampled at the start of every phase.

Top module: `cpuRstSlice`

## Requirements
- R1: `busAddr` selects the word: value 0 is core 0 and value 1 is core 1. A write is captured on the rising clock edge while `busWr` is high, and it affects only the addressed core. `busRdata` shows the addressed word combinationally.
- R2: A write changes the reset control bit (bit 0) only if bit 16 of the same write data is one. Without bit 16, the write starts no sequence and leaves the readback unchanged.
- R3: Readback holds the reset control bit at bit 0, the flush request at bit 4 and the done flag at bit 12. All other bits, including write-enable bits 16, 20 and 28, read as zero.
- R4: On core 0, writing a one to the control bit starts three consecutive clock-stop phases. In order, the core's reset is low, then high, then low again. Bit 0 reads one until the sequence ends, reset is never high while the clock runs, and a write to bit 0 during the sequence is ignored.
- R5: On core 1, writing a one while idle runs two stopped phases (reset low, then reset high), after which reset stays high with the clock enabled. Writing a zero while held runs two stopped phases (reset high, then reset low) and returns to idle. A write that does not change the bit has no effect.
- R6: A core's reset output rises or falls only in a cycle where its clock enable is low, and its clock enable was also low the cycle before.
- R7: The done flag of a core is set when its removal phase ends. It is cleared by a write with bits 12 and 28 both one. A write with bit 12 but not bit 28 leaves it set.
- R8: If the done flag is set and cleared in the same cycle, it ends up set.
- R9: Writing bit 4 with write-enable bit 20 raises `flushReq` from the next cycle. The request stays high until a cycle in which `flushDone` is high for that core. Further writes during a flush are ignored, and `flushDone` is ignored when no request is pending. If a set write and `flushDone` fall in the same cycle while idle, the request is raised.
- R10: After reset, all readback bits are zero, every `coreRst` is low, every `coreClkEn` is high and every `flushReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Core word select |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data with write-enable bits |
| busRdata | output | 32 | Read data of addressed word |
| stopTicks | input | 4 | Clock-stop phase length in ticks |
| flushDone | input | NUM_CORES | Flush complete pulse per core |
| coreRst | output | NUM_CORES | Active-high core reset |
| coreClkEn | output | NUM_CORES | Core clock enable, low during stop phases |
| flushReq | output | NUM_CORES | Active-high cache flush request |

## Verification
Two pairs of events can land on the same edge. The first is the end of a removal phase, which sets the done flag, and a software clear of that flag. The second is a flush set write and a flush-complete pulse. The bench times a done-clear write so that it is captured on the exact edge on which the self-clearing sequence ends, and expects the flag to read one afterwards. It also drives a flush set write together with `flushDone` on an idle core and expects the request to be raised. Randomly chosen phase lengths and cores give the counted clock-stop and reset-high windows against the lengths the bench computes.

// File: rtl/cpuRstPkg.sv
package cpuRstPkg;
  localparam int CTRL_BIT  = 0;
  localparam int FLUSH_BIT = 4;
  localparam int DONE_BIT  = 12;
  localparam int WE_OFS    = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STOP_PRE,
    ST_STOP_ON,
    ST_HELD,
    ST_STOP_OFF,
    ST_STOP_POST
  } seqState_t;

  typedef struct packed {
    logic ctrlWe;
    logic ctrlVal;
  } wrReq_t;

  typedef struct packed {
    logic ctrlSet;
    logic ctrlClr;
    logic timerLoad;
    logic setDone;
  } seqStrobe_t;
endpackage

// File: rtl/rstRegPath.sv
module rstRegPath
  import cpuRstPkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int TICK_CYCLES = 25,
  parameter int ADDR_W      = 1,
  parameter int CNT_W       = 9
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic                               busWr,
  input  logic [31:0]                        busWdata,
  input  logic [3:0]                         stopTicks,
  input  logic [NUM_CORES-1:0]               flushDone,
  input  seqStrobe_t [NUM_CORES-1:0]         strb,
  output wrReq_t [NUM_CORES-1:0]             wrReq,
  output logic [NUM_CORES-1:0]               timerZero,
  output logic [NUM_CORES-1:0]               flushReq,
  output logic [31:0]                        busRdata
);
  logic [NUM_CORES-1:0][31:0] words;
  logic [CNT_W-1:0]           loadVal;
  logic                       unusedWdata;

  assign loadVal = CNT_W'(stopTicks) * CNT_W'(TICK_CYCLES);
  assign unusedWdata = ^{busWdata[31:29], busWdata[27:21], busWdata[19:17],
                         busWdata[15:13], busWdata[11:5], busWdata[3:1]};

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    logic             wrHit, flushSet, doneClr;
    logic             ctrlQ, doneQ, flushQ;
    logic [CNT_W-1:0] cntQ;

    assign wrHit    = busWr && (busAddr == ADDR_W'(g));
    assign flushSet = wrHit && busWdata[WE_OFS + FLUSH_BIT] && busWdata[FLUSH_BIT];
    assign doneClr  = wrHit && busWdata[WE_OFS + DONE_BIT] && busWdata[DONE_BIT];
    assign wrReq[g].ctrlWe  = wrHit && busWdata[WE_OFS + CTRL_BIT];
    assign wrReq[g].ctrlVal = busWdata[CTRL_BIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ  <= 1'b0;
        doneQ  <= 1'b0;
        flushQ <= 1'b0;
        cntQ   <= '0;
      end else begin
        if (strb[g].ctrlSet)      ctrlQ <= 1'b1;
        else if (strb[g].ctrlClr) ctrlQ <= 1'b0;

        if (strb[g].setDone) doneQ <= 1'b1;
        else if (doneClr)    doneQ <= 1'b0;

        if (!flushQ)           flushQ <= flushSet;
        else if (flushDone[g]) flushQ <= 1'b0;

        if (strb[g].timerLoad) cntQ <= loadVal;
        else if (cntQ != '0)   cntQ <= cntQ - 1'b1;
      end
    end

    assign timerZero[g] = (cntQ == '0);
    assign flushReq[g]  = flushQ;
    assign words[g]     = {19'd0, doneQ, 7'd0, flushQ, 3'd0, ctrlQ};
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (busAddr == ADDR_W'(i)) busRdata = words[i];
    end
  end
endmodule

// File: rtl/rstSeqCtrl.sv
module rstSeqCtrl
  import cpuRstPkg::*;
#(
  parameter int                   NUM_CORES = 2,
  parameter logic [NUM_CORES-1:0] AUTO_MASK = 2'b01
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  wrReq_t [NUM_CORES-1:0]      wrReq,
  input  logic [NUM_CORES-1:0]        timerZero,
  output seqStrobe_t [NUM_CORES-1:0]  strb,
  output logic [NUM_CORES-1:0]        coreRst,
  output logic [NUM_CORES-1:0]        coreClkEn
);
  for (genvar g = 0; g < NUM_CORES; g++) begin : gSeq
    seqState_t  stQ, stNxt;
    seqStrobe_t s;
    logic       isAuto;

    assign isAuto = AUTO_MASK[g];

    always_comb begin
      stNxt = stQ;
      s     = '0;
      unique case (stQ)
        ST_IDLE: if (wrReq[g].ctrlWe && wrReq[g].ctrlVal) begin
          s.ctrlSet   = 1'b1;
          s.timerLoad = 1'b1;
          stNxt       = ST_STOP_PRE;
        end
        ST_STOP_PRE: if (timerZero[g]) begin
          s.timerLoad = 1'b1;
          stNxt       = ST_STOP_ON;
        end
        ST_STOP_ON: if (timerZero[g]) begin
          s.timerLoad = 1'b1;
          stNxt       = isAuto ? ST_STOP_POST : ST_HELD;
        end
        ST_HELD: if (wrReq[g].ctrlWe && !wrReq[g].ctrlVal) begin
          s.ctrlClr   = 1'b1;
          s.timerLoad = 1'b1;
          stNxt       = ST_STOP_OFF;
        end
        ST_STOP_OFF: if (timerZero[g]) begin
          s.timerLoad = 1'b1;
          stNxt       = ST_STOP_POST;
        end
        ST_STOP_POST: if (timerZero[g]) begin
          s.setDone = 1'b1;
          s.ctrlClr = isAuto;
          stNxt     = ST_IDLE;
        end
        default: stNxt = ST_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stQ <= ST_IDLE;
      else       stQ <= stNxt;
    end

    assign strb[g]      = s;
    assign coreRst[g]   = (stQ == ST_STOP_ON) || (stQ == ST_HELD) || (stQ == ST_STOP_OFF);
    assign coreClkEn[g] = (stQ == ST_IDLE) || (stQ == ST_HELD);
  end
endmodule

// File: rtl/cpuRstSlice.sv
module cpuRstSlice
  import cpuRstPkg::*;
#(
  parameter int                   NUM_CORES   = 2,
  parameter int                   TICK_CYCLES = 25,
  parameter logic [NUM_CORES-1:0] AUTO_MASK   = 2'b01,
  localparam int                  ADDR_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [3:0]           stopTicks,
  input  logic [NUM_CORES-1:0] flushDone,
  output logic [NUM_CORES-1:0] coreRst,
  output logic [NUM_CORES-1:0] coreClkEn,
  output logic [NUM_CORES-1:0] flushReq
);
  localparam int CNT_W = $clog2(15 * TICK_CYCLES + 1) + 1;

  wrReq_t     [NUM_CORES-1:0] wrReq;
  seqStrobe_t [NUM_CORES-1:0] strb;
  logic       [NUM_CORES-1:0] timerZero;

  rstRegPath #(
    .NUM_CORES(NUM_CORES), .TICK_CYCLES(TICK_CYCLES),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .stopTicks(stopTicks), .flushDone(flushDone),
    .strb(strb), .wrReq(wrReq), .timerZero(timerZero),
    .flushReq(flushReq), .busRdata(busRdata)
  );

  rstSeqCtrl #(
    .NUM_CORES(NUM_CORES), .AUTO_MASK(AUTO_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .timerZero(timerZero),
    .strb(strb), .coreRst(coreRst), .coreClkEn(coreClkEn)
  );
endmodule

// File: rtl/cpuRstChecker.sv
module cpuRstChecker #(
  parameter int                   NUM_CORES = 2,
  parameter int                   ADDR_W    = 1,
  parameter logic [NUM_CORES-1:0] AUTO_MASK = 2'b01
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWr,
  input logic [31:0]          busWdata,
  input logic [NUM_CORES-1:0] flushDone,
  input logic [NUM_CORES-1:0] coreRst,
  input logic [NUM_CORES-1:0] coreClkEn,
  input logic [NUM_CORES-1:0] flushReq
);
  for (genvar g = 0; g < NUM_CORES; g++) begin : gChk
    assert_rst_rise_stopped_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(coreRst[g]) |-> (!coreClkEn[g] && $past(!coreClkEn[g])));

    assert_rst_fall_stopped_R6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(coreRst[g]) |-> (!coreClkEn[g] && $past(!coreClkEn[g])));

    assert_flush_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flushReq[g]) |-> $past(flushDone[g]));

    assert_flush_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flushReq[g]) |->
        $past(busWr && (busAddr == ADDR_W'(g)) && busWdata[20] && busWdata[4]));

    assert_seq_needs_write_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(coreClkEn[g]) && !coreRst[g]) |->
        $past(busWr && (busAddr == ADDR_W'(g)) && busWdata[16] && busWdata[0]));

    if (AUTO_MASK[g]) begin : gAuto
      assert_auto_never_runs_in_rst_R4: assert property (@(posedge clk) disable iff (!rstN)
        coreRst[g] |-> !coreClkEn[g]);
    end
  end
endmodule

bind cpuRstSlice cpuRstChecker #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .AUTO_MASK(AUTO_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .flushDone(flushDone), .coreRst(coreRst),
  .coreClkEn(coreClkEn), .flushReq(flushReq)
);

// File: tb/sim_cpuRstSlice.sv
`timescale 1ns/1ps
module sim_cpuRstSlice;
  localparam int TICKS = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [0:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  stopTicks = '0;
  logic [1:0]  flushDone = '0;
  logic [1:0]  coreRst, coreClkEn, flushReq;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  cpuRstSlice #(.NUM_CORES(2), .TICK_CYCLES(TICKS), .AUTO_MASK(2'b01)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .stopTicks(stopTicks),
    .flushDone(flushDone), .coreRst(coreRst), .coreClkEn(coreClkEn),
    .flushReq(flushReq)
  );

  function automatic int phaseLen(int p);
    return p * TICKS + 1;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(int a, logic [31:0] d);
    busAddr = 1'(a); busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic readWord(int a, output logic [31:0] v);
    busAddr = 1'(a);
    #1;
    v = busRdata;
  endtask

  task automatic measure(int c, output int low, output int rs, output int first);
    low = 0; rs = 0; first = -1;
    for (int idx = 0; idx < 2000 && !coreClkEn[c]; idx++) begin
      if (coreRst[c]) begin
        rs++;
        if (first < 0) first = idx;
      end
      low++;
      @(negedge clk);
    end
  endtask

  task automatic runSeq(int c, int p);
    int low, rs, first, L1;
    logic [31:0] v;
    L1 = phaseLen(p);
    stopTicks = 4'(p);
    busWrite(c, 32'h1000_1000);
    busWrite(c, 32'h0001_0001);
    measure(c, low, rs, first);
    readWord(c, v);
    if (c == 0) begin
      chk(low == 3 * L1, "R4 core0 stop cycles", low, 3 * L1);
      chk(rs == L1 && first == L1, "R4 core0 reset window", rs * 1000 + first, L1 * 1000 + L1);
      chk(v == 32'h0000_1000, "R7 core0 done after sequence", int'(v), 32'h1000);
    end else begin
      chk(low == 2 * L1, "R5 core1 apply stop cycles", low, 2 * L1);
      chk(rs == L1 && first == L1, "R5 core1 apply reset window", rs * 1000 + first, L1 * 1000 + L1);
      chk(coreRst[1] && v == 32'h1, "R5 core1 held", int'(v), 1);
      repeat ($urandom_range(1, 5)) @(negedge clk);
      busWrite(1, 32'h0001_0001);
      chk(coreRst[1] && coreClkEn[1], "R5 repeated set ignored", int'({coreRst[1], coreClkEn[1]}), 3);
      busWrite(1, 32'h0001_0000);
      measure(1, low, rs, first);
      readWord(1, v);
      chk(low == 2 * L1, "R5 core1 release stop cycles", low, 2 * L1);
      chk(rs == L1 && first == 0, "R5 core1 release reset window", rs * 1000 + first, L1 * 1000);
      chk(!coreRst[1] && v == 32'h0000_1000, "R7 core1 done after release", int'(v), 32'h1000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int low, rs, first;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    readWord(0, v);
    chk(v == 0, "R10 core0 readback", int'(v), 0);
    readWord(1, v);
    chk(v == 0, "R10 core1 readback", int'(v), 0);
    chk(coreRst == 2'b00 && coreClkEn == 2'b11 && flushReq == 2'b00, "R10 outputs",
        int'({coreRst, coreClkEn, flushReq}), 6'b001100);

    // R2 no write enable, R3 readback of enable bits
    busWrite(0, 32'h0000_0001);
    repeat (2) @(negedge clk);
    readWord(0, v);
    chk(coreClkEn[0] && v == 0, "R2 control write without enable", int'(v), 0);
    busWrite(0, 32'hFFFF_FFFF);
    readWord(0, v);
    chk((v & 32'hFFFF_EFEE) == 0, "R3 only control/flush/done bits read", int'(v & 32'hFFFF_EFEE), 0);
    measure(0, low, rs, first);
    busWrite(0, 32'h1000_1000);
    flushDone = 2'b01; @(negedge clk); flushDone = 2'b00;
    readWord(0, v);
    chk(v == 0, "R3 clean after full write", int'(v), 0);

    // R1 address selection via flush
    busWrite(1, 32'h0010_0010);
    readWord(0, v);
    chk(flushReq == 2'b10 && v == 0, "R1 write hits addressed core only", int'(flushReq), 2);
    // R9 repeated and zero writes ignored, done clears
    busWrite(1, 32'h0010_0000);
    busWrite(1, 32'h0010_0010);
    chk(flushReq[1], "R9 flush held through writes", int'(flushReq[1]), 1);
    flushDone = 2'b10; @(negedge clk); flushDone = 2'b00;
    chk(!flushReq[1], "R9 flush cleared by completion", int'(flushReq[1]), 0);
    flushDone = 2'b01; @(negedge clk); flushDone = 2'b00;
    busWrite(0, 32'h0010_0000);
    chk(flushReq == 2'b00, "R9 idle completion and zero write ignored", int'(flushReq), 0);
    // R9 same-cycle set and completion
    busAddr = 1'b0; busWdata = 32'h0010_0010; busWr = 1'b1; flushDone = 2'b01;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0; flushDone = 2'b00;
    chk(flushReq[0], "R9 set wins over idle completion", int'(flushReq[0]), 1);
    flushDone = 2'b01; @(negedge clk); flushDone = 2'b00;

    // R4 R5 R7 directed extremes
    runSeq(0, 0);
    runSeq(0, 15);
    runSeq(1, 0);
    runSeq(1, 15);

    // R7 clear without enable keeps done
    busWrite(1, 32'h0000_1000);
    readWord(1, v);
    chk(v == 32'h1000, "R7 clear without enable ignored", int'(v), 32'h1000);
    busWrite(1, 32'h1000_1000);
    readWord(1, v);
    chk(v == 0, "R7 clear with enable", int'(v), 0);

    // R5 clear write while idle ignored
    busWrite(1, 32'h0001_0000);
    chk(coreClkEn[1] && !coreRst[1], "R5 clear while idle ignored", int'(coreClkEn[1]), 1);

    // R4 rewrite during sequence ignored
    stopTicks = 4'd2;
    busWrite(0, 32'h1000_1000);
    busWrite(0, 32'h0001_0001);
    busWrite(0, 32'h0001_0001);
    measure(0, low, rs, first);
    chk(low == 3 * phaseLen(2) - 1, "R4 rewrite mid-sequence ignored", low, 3 * phaseLen(2) - 1);

    // R8 done set and clear on the same edge
    busWrite(0, 32'h1000_1000);
    busWrite(0, 32'h0001_0001);
    repeat (3 * phaseLen(2) - 1) @(negedge clk);
    readWord(0, v);
    chk(v == 32'h1, "R8 done still clear before final edge", int'(v), 1);
    busWrite(0, 32'h1000_1000);
    readWord(0, v);
    chk(v == 32'h1000, "R8 set wins over clear", int'(v), 32'h1000);

    // random phase lengths and cores
    for (int it = 0; it < 10; it++) begin
      runSeq(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
    end

    finishRun();
  end
endmodule